// File: doc/BRIEF.md
# Dual-Channel Tamper Detection Controller

This block watches a set of external tamper switch inputs (two by default) and turns each into a sticky tamper flag. Each channel can raise an interrupt request. Every channel has its own four control bits: an arm bit, an interrupt enable, a switch-type select and a trigger-level select. With these, one design serves both normally-open and normally-closed switches, wired to pull the pin either high or low. Each pin passes through a synchronizer before any decision is taken.

A flag can be cleared in only one way: software disarms that channel. Software cannot write the flag directly. A shared battery-interrupt enable decides whether a tamper may still drive the interrupt pin while the system reports battery operation. Software reaches the control bits and the flags through a small register port. Writes are synchronous and reads are combinational.

Top module: `tamper_guard`

## Requirements
- R1: A synchronous reset clears every control bit, the battery-interrupt enable and all flags. While and after reset, `irq_out` is 0.
- R2: A change on a tamper pin reaches its flag exactly three rising clock edges after the pin changes: two synchronizer stages, then the flag register.
- R3: A flag is set at the first clock edge at which its channel is armed and the tamper condition holds. The flag stays set while the channel stays armed, even after the condition goes away.
- R4: A flag is 0 on the clock edge after its arm bit is 0. While the arm bit is 0, the flag cannot be set.
- R5: Writes to the flags address leave the flags unchanged. Reading any address leaves the flags unchanged.
- R6: Control byte of channel k: bit 0 arm, bit 1 interrupt enable, bit 2 switch type (1 = normally open, 0 = normally closed), bit 3 trigger level (1 = high, 0 = low). For a normally open switch, tamper means the pin equals the trigger level. For a normally closed switch, tamper means the pin differs from the trigger level.
- R7: When `on_battery` is 0, `irq_out` is 1 exactly when some channel has its flag and its interrupt enable both set. `irq_out` falls in the same cycle in which the last contributing flag clears.
- R8: When `on_battery` is 1, `irq_out` is 0 unless the battery-interrupt enable (bit 0 at address 2) is 1.
- R9: The register map is as follows. Channel k's control byte is at address k, and bits 7:4 read as 0. The battery-interrupt enable is at address 2. The flags are at address 0xF, bit k for channel k. Unmapped addresses read 0. `rd_data` follows `addr` combinationally.
- R10: Suppose a channel is disarmed and then re-armed while its tamper condition is still present. Its flag sets again on the edge after re-arming, and so does the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tamper_pin | input | 2 | Raw tamper switch inputs, one per channel |
| on_battery | input | 1 | 1 while the system runs on battery |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq_out | output | 1 | Tamper interrupt request, active high |

## Verification
The hardest state to reach is the stale-event case: a flag has been set, the condition is still present, and software disarms and then re-arms the channel. To get there, the stimulus holds the pin at its tamper level for the whole sequence. It checks that the flag and the interrupt are gone for exactly one window and then come back on the edge after re-arming. Random trials choose switch type, trigger level, pin levels and battery state, and every trial is followed by a second pin change to exercise the sticky behaviour. Directed sequences measure the three-edge latency and the gating on battery.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;
   // control byte layout, bit 0 upward: arm, irq enable, switch type, level
   typedef struct packed {
      logic lvl_high;
      logic sw_open;
      logic irq_en;
      logic arm;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tamper_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
   import tamper_guard_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      pin_s,
   input  chan_cfg_t cfg,
   output logic      flag_o
);
   logic hit;
   logic flag_q;

   // open switch: pin at the chosen level; closed switch: pin away from it
   always_comb begin
      if (cfg.sw_open) hit = (pin_s == cfg.lvl_high);
      else             hit = (pin_s != cfg.lvl_high);
   end

   always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (!cfg.arm) flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/tamper_regs.sv
module tamper_regs
   import tamper_guard_pkg::*;
#(
   parameter int CH        = 2,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int FLAG_ADDR = 15
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [CH-1:0]          flags,
   output chan_cfg_t [CH-1:0]     cfg_o,
   output logic                   bat_ie_o,
   output logic [DATA_W-1:0]      rd_data
);
   localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(CH);
   localparam logic [ADDR_W-1:0] FLG_A = ADDR_W'(FLAG_ADDR);

   generate
      if (DATA_W < CFG_W || DATA_W < CH) begin : g_bad_w
         $error("data width too small for control or flag fields");
      end
      if (CH + 1 >= FLAG_ADDR || FLAG_ADDR >= (1 << ADDR_W)) begin : g_bad_a
         $error("register map does not fit the address space");
      end
   endgenerate

   chan_cfg_t [CH-1:0] cfg_q;
   logic               bat_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         bat_q <= 1'b0;
      end else if (wr_en) begin
         for (int k = 0; k < CH; k++) begin
            if (addr == ADDR_W'(k)) cfg_q[k] <= chan_cfg_t'(wr_data[CFG_W-1:0]);
         end
         if (addr == GLB_A) bat_q <= wr_data[0];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < CH; k++) begin
         if (addr == ADDR_W'(k)) rd_data[CFG_W-1:0] = cfg_q[k];
      end
      if (addr == GLB_A) rd_data[0] = bat_q;
      if (addr == FLG_A) rd_data[CH-1:0] = flags;
   end

   assign cfg_o    = cfg_q;
   assign bat_ie_o = bat_q;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
   import tamper_guard_pkg::*;
#(
   parameter int CH          = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int FLAG_ADDR   = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CH-1:0]     tamper_pin,
   input  logic              on_battery,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_out
);
   generate
      if (CH < 1) begin : g_bad_ch
         $error("at least one channel required");
      end
   endgenerate

   chan_cfg_t [CH-1:0] cfg;
   logic [CH-1:0]      pin_s;
   logic [CH-1:0]      flag_q;
   logic [CH-1:0]      ch_en;
   logic [CH-1:0]      ch_ie;
   logic               bat_ie;

   tamper_regs #(
      .CH(CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .flags(flag_q), .cfg_o(cfg), .bat_ie_o(bat_ie), .rd_data(rd_data)
   );

   for (genvar k = 0; k < CH; k++) begin : g_ch
      tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst(rst), .d_in(tamper_pin[k]), .q_out(pin_s[k])
      );
      tamper_chan u_chan (
         .clk(clk), .rst(rst), .pin_s(pin_s[k]), .cfg(cfg[k]), .flag_o(flag_q[k])
      );
      assign ch_en[k] = cfg[k].arm;
      assign ch_ie[k] = cfg[k].irq_en;
   end

   assign irq_out = (|(flag_q & ch_ie)) & (~on_battery | bat_ie);
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk #(
   parameter int CH = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int FLAG_ADDR = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              on_battery,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq_out,
   input logic [CH-1:0]     flag_q,
   input logic [CH-1:0]     ch_en,
   input logic [CH-1:0]     ch_ie,
   input logic              bat_ie
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (flag_q == '0 && ch_en == '0 && !bat_ie && !irq_out));

   for (genvar k = 0; k < CH; k++) begin : g_k
      p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
         (flag_q[k] && ch_en[k]) |=> flag_q[k]);
      p_disarm_clears_r4: assert property (@(posedge clk) disable iff (rst)
         !ch_en[k] |=> !flag_q[k]);
      p_set_needs_arm_r4: assert property (@(posedge clk) disable iff (rst)
         $rose(flag_q[k]) |-> $past(ch_en[k]));
   end

   p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
      irq_out |-> (flag_q & ch_ie) != '0);
   p_irq_battery_r8: assert property (@(posedge clk) disable iff (rst)
      (on_battery && !bat_ie) |-> !irq_out);
   p_flag_read_r9: assert property (@(posedge clk) disable iff (rst)
      (addr == ADDR_W'(FLAG_ADDR)) |-> (rd_data[CH-1:0] == flag_q));
endmodule

bind tamper_guard tamper_guard_chk #(
   .CH(CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .on_battery(on_battery), .addr(addr),
   .rd_data(rd_data), .irq_out(irq_out), .flag_q(flag_q), .ch_en(ch_en),
   .ch_ie(ch_ie), .bat_ie(bat_ie)
);

// File: tb/sim_tamper_guard.sv
module sim_tamper_guard;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] tamper_pin = 2'b00;
   logic       on_battery = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'h0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tamper_guard u0 (
      .clk(clk), .rst(rst), .tamper_pin(tamper_pin), .on_battery(on_battery),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .irq_out(irq_out)
   );

   function automatic logic cond(input logic pin, input logic sw_open, input logic lvl);
      if (sw_open) return pin == lvl;
      return pin != lvl;
   endfunction

   function automatic logic [7:0] cbyte(input logic lvl, input logic sw_open,
                                        input logic ie, input logic en);
      return {4'b0000, lvl, sw_open, ie, en};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [1:0] expf;
      void'($urandom(32'h1d2c3b4a));

      // R1: reset state
      idle(3);
      @(negedge clk); rst = 1'b0;
      rd(4'h0, v); chk("R1 ctrl0", v, 8'h00);
      rd(4'h1, v); chk("R1 ctrl1", v, 8'h00);
      rd(4'h2, v); chk("R1 bat", v, 8'h00);
      rd(4'hF, v); chk("R1 flags", v, 8'h00);
      chk("R1 irq", {7'b0, irq_out}, 8'h00);

      // R9: map and readback, upper bits dropped
      wr(4'h0, 8'hF6); rd(4'h0, v); chk("R9 ctrl0 readback", v, 8'h06);
      wr(4'h1, 8'hA9); rd(4'h1, v); chk("R9 ctrl1 readback", v, 8'h09);
      wr(4'h2, 8'hFF); rd(4'h2, v); chk("R9 bat readback", v, 8'h01);
      rd(4'h7, v); chk("R9 unmapped", v, 8'h00);
      wr(4'h0, 8'h00); wr(4'h1, 8'h00); wr(4'h2, 8'h00);

      // R2: three-edge latency, normally open active high on ch0
      tamper_pin = 2'b00;
      wr(4'h0, cbyte(1, 1, 1, 1));
      idle(4);
      rd(4'hF, v); chk("R2 before", v, 8'h00);
      @(negedge clk); tamper_pin[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      addr = 4'hF; #1 chk("R2 two edges", rd_data, 8'h00);
      @(negedge clk);
      #1 chk("R2 three edges", rd_data, 8'h01);
      chk("R7 irq raised", {7'b0, irq_out}, 8'h01);

      // R3: sticky after condition leaves
      @(negedge clk); tamper_pin[0] = 1'b0;
      idle(5);
      rd(4'hF, v); chk("R3 sticky", v, 8'h01);

      // R5: flag writes and reads have no effect
      wr(4'hF, 8'h00); idle(2);
      rd(4'hF, v); chk("R5 write zero ignored", v, 8'h01);
      rd(4'hF, v); chk("R5 reread", v, 8'h01);

      // R4: disarm clears, irq falls with it; no set while disarmed
      wr(4'h0, cbyte(1, 1, 1, 0));
      @(negedge clk);
      rd(4'hF, v); chk("R4 cleared", v, 8'h00);
      chk("R7 irq fell", {7'b0, irq_out}, 8'h00);
      tamper_pin[0] = 1'b1; idle(5);
      rd(4'hF, v); chk("R4 disarmed stays clear", v, 8'h00);
      wr(4'hF, 8'hFF); idle(2);
      rd(4'hF, v); chk("R5 write ones ignored", v, 8'h00);

      // R10: stale event returns on re-arm
      wr(4'h0, cbyte(1, 1, 1, 1));
      @(negedge clk);
      rd(4'hF, v); chk("R10 set again", v, 8'h01);
      chk("R10 irq again", {7'b0, irq_out}, 8'h01);
      wr(4'h0, cbyte(1, 1, 1, 0));
      @(negedge clk);
      chk("R10 irq gone", {7'b0, irq_out}, 8'h00);
      wr(4'h0, cbyte(1, 1, 1, 1));
      @(negedge clk);
      chk("R10 irq back", {7'b0, irq_out}, 8'h01);

      // R8: battery gating
      @(negedge clk); on_battery = 1'b1; #1;
      chk("R8 blocked", {7'b0, irq_out}, 8'h00);
      wr(4'h2, 8'h01); #1;
      chk("R8 allowed", {7'b0, irq_out}, 8'h01);
      wr(4'h2, 8'h00); on_battery = 1'b0; #1;
      chk("R7 mains", {7'b0, irq_out}, 8'h01);
      wr(4'h0, 8'h00);

      // R6: normally closed, active low on ch1: idle pin is low
      tamper_pin[1] = 1'b0;
      wr(4'h1, cbyte(0, 0, 1, 1)); idle(4);
      rd(4'hF, v); chk("R6 closed idle", v, 8'h00);
      tamper_pin[1] = 1'b1; idle(4);
      rd(4'hF, v); chk("R6 closed opened", v, 8'h02);
      wr(4'h1, 8'h00);

      // random trials: R3 R6 R7 R8
      for (int t = 0; t < 60; t++) begin
         logic [1:0] ie, sw, lv, p;
         logic bat, bie;
         ie = 2'($urandom); sw = 2'($urandom); lv = 2'($urandom);
         bat = 1'($urandom); bie = 1'($urandom);
         for (int k = 0; k < 2; k++) wr(4'(k), cbyte(lv[k], sw[k], ie[k], 0));
         wr(4'h2, {7'b0, bie});
         p = 2'($urandom); tamper_pin = p; on_battery = bat;
         idle(4);
         for (int k = 0; k < 2; k++) wr(4'(k), cbyte(lv[k], sw[k], ie[k], 1));
         idle(3);
         for (int k = 0; k < 2; k++) expf[k] = cond(p[k], sw[k], lv[k]);
         rd(4'hF, v); chk("R6 random flags", v, {6'b0, expf});
         chk("R8 random irq", {7'b0, irq_out},
             {7'b0, (|(expf & ie)) & (!bat | bie)});
         p = 2'($urandom); tamper_pin = p; idle(4);
         for (int k = 0; k < 2; k++) expf[k] = expf[k] | cond(p[k], sw[k], lv[k]);
         rd(4'hF, v); chk("R3 random sticky", v, {6'b0, expf});
         chk("R7 random irq", {7'b0, irq_out},
             {7'b0, (|(expf & ie)) & (!bat | bie)});
      end

      // R1: reset mid-operation
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      rd(4'hF, v); chk("R1 flags after reset", v, 8'h00);
      rd(4'h0, v); chk("R1 ctrl after reset", v, 8'h00);
      chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule